// File: doc/BRIEF.md
# Repeated-Character Escape Detector

This block sits behind a UART receiver and watches the stream of received bytes for a guarded run of one repeated character, the kind of run a modem-style link uses to drop from data mode into command mode. The run counts only when the line was quiet for a set time before its first character. Consecutive characters in the run must follow each other within a set gap. The line must then stay quiet for a set time after the last character. All three times are counted in clock cycles. When a complete guarded run is seen, a sticky status bit is set. The status drives an interrupt line whenever the interrupt enable is on.

A single cycle-counting idle timer is shared by all three time checks. It restarts on every received byte and saturates at its maximum. A small matcher walks through searching, counting and post-guard waiting. Software programs the block through a simple write port carrying an address, data and a write strobe. Any write to one of the pattern registers returns the matcher to its search state.

Top module: `esc_seq_detector`

## Requirements
- R1: After reset the status and interrupt outputs are 0. The registers reset as follows: the character is 0x2B, the run length is 3, the gap limit is the RST_GAP parameter, the pre-guard and post-guard are each 10 cycles, and the interrupt enable is 0. Register addresses: 0 character (low 8 bits), 1 run length (low 8 bits), 2 gap limit, 3 pre-guard, 4 post-guard, 5 control (bit 0 interrupt enable; bit 1 written as 1 clears the status).
- R2: A byte starts a run only if it equals the character register and at least pre-guard idle cycles immediately preceded it. Idle time since reset counts. A different character never starts a run.
- R3: Each further byte of a run must equal the character and follow the previous run byte after at most gap-limit idle cycles. A byte that fails either test ends the run.
- R4: Let the last byte of a full run arrive in cycle t. If no byte arrives in cycles t+1 through t+post+1, the status reads 1 from cycle t+post+2 onwards. A run length of 0 acts as 1.
- R5: A byte arriving while the post-guard is pending cancels the detection. That byte, like any byte that ends a run, is then judged as a possible first byte under R2.
- R6: The idle count restarts on every byte and saturates at its all-ones value instead of wrapping.
- R7: A write to any of addresses 0 to 4 returns the matcher to search, discarding a partial run.
- R8: The status stays set until a control write with bit 1 set. A control write with bit 1 clear leaves it unchanged. A detection in the same cycle as a clear leaves the status set.
- R9: The interrupt output equals the status AND the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | CW (8) | Received byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | TW (24) | Register write data |
| det_status | output | 1 | Sticky detection status |
| irq | output | 1 | Interrupt, status gated by enable |

## Verification
Two events can fall in the same cycle: the matcher declaring a detection at the end of the post-guard, and a software clear of the status. The bench times a control write with the clear bit so that it lands exactly in the post-guard's final cycle. The status must then read 1. A later clear in a quiet cycle must drop it to 0. A second collision places a pattern-register write in the middle of a run, and the following byte must be judged as a fresh start rather than as a continuation.

// File: rtl/escdet_pkg.sv
package escdet_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CHAR  = 3'd0;
  localparam logic [AW-1:0] A_COUNT = 3'd1;
  localparam logic [AW-1:0] A_GAP   = 3'd2;
  localparam logic [AW-1:0] A_PRE   = 3'd3;
  localparam logic [AW-1:0] A_POST  = 3'd4;
  localparam logic [AW-1:0] A_CTRL  = 3'd5;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef enum logic [1:0] {
    MS_SEARCH = 2'd0,
    MS_COUNT  = 2'd1,
    MS_POST   = 2'd2
  } match_st_e;
endpackage

// File: rtl/escdet_cfg.sv
module escdet_cfg
  import escdet_pkg::*;
#(
  parameter int CW = 8,
  parameter int NW = 8,
  parameter int TW = 24,
  parameter logic [CW-1:0] RST_CHAR  = 8'h2B,
  parameter logic [NW-1:0] RST_COUNT = 8'd3,
  parameter logic [TW-1:0] RST_GAP   = 24'd10000,
  parameter logic [TW-1:0] RST_PRE   = 24'd10,
  parameter logic [TW-1:0] RST_POST  = 24'd10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [TW-1:0] wdata,
  output logic [CW-1:0] pat_char,
  output logic [NW-1:0] pat_count,
  output logic [TW-1:0] gap_lim,
  output logic [TW-1:0] pre_lim,
  output logic [TW-1:0] post_lim,
  output logic          irq_en,
  output logic          pat_wr,
  output logic          clr_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_char  <= RST_CHAR;
      pat_count <= RST_COUNT;
      gap_lim   <= RST_GAP;
      pre_lim   <= RST_PRE;
      post_lim  <= RST_POST;
      irq_en    <= 1'b0;
    end else if (we) begin
      case (addr)
        A_CHAR:  pat_char  <= wdata[CW-1:0];
        A_COUNT: pat_count <= wdata[NW-1:0];
        A_GAP:   gap_lim   <= wdata;
        A_PRE:   pre_lim   <= wdata;
        A_POST:  post_lim  <= wdata;
        A_CTRL:  irq_en    <= wdata[CTRL_EN_BIT];
        default: ;
      endcase
    end
  end

  // Pattern-register writes restart the matcher; control writes do not.
  assign pat_wr  = we && (addr <= A_POST);
  assign clr_req = we && (addr == A_CTRL) && wdata[CTRL_CLR_BIT];
endmodule

// File: rtl/escdet_idle.sv
module escdet_idle #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  output logic [TW-1:0] idle_cnt
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
    logic [TW-1:0] r;
    r = (v == CNT_MAX) ? v : v + 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        idle_cnt <= '0;
    else if (rx_valid) idle_cnt <= '0;
    else               idle_cnt <= sat_inc(idle_cnt);
  end
endmodule

// File: rtl/escdet_match.sv
module escdet_match
  import escdet_pkg::*;
#(
  parameter int CW = 8,
  parameter int NW = 8,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_byte,
  input  logic [CW-1:0] pat_char,
  input  logic [NW-1:0] pat_count,
  input  logic [TW-1:0] gap_lim,
  input  logic [TW-1:0] pre_lim,
  input  logic [TW-1:0] post_lim,
  input  logic [TW-1:0] idle_cnt,
  input  logic          restart,
  output logic          detect,
  output logic          in_search
);
  function automatic logic [NW-1:0] run_target(input logic [NW-1:0] c);
    return (c == '0) ? NW'(1) : c;
  endfunction

  match_st_e     st, st_n;
  logic [NW-1:0] hits, hits_n;
  logic [NW-1:0] target;
  logic [NW-1:0] hits_inc;
  logic          is_pat;
  logic          first_ok;
  logic          next_ok;
  match_st_e     start_st;

  assign target   = run_target(pat_count);
  assign hits_inc = hits + 1'b1;
  assign is_pat   = (rx_byte == pat_char);
  assign first_ok = rx_valid && is_pat && (idle_cnt >= pre_lim);
  assign next_ok  = rx_valid && is_pat && (idle_cnt <= gap_lim);
  assign start_st = (target == NW'(1)) ? MS_POST : MS_COUNT;

  always_comb begin
    st_n   = st;
    hits_n = hits;
    detect = 1'b0;
    if (restart) begin
      st_n   = MS_SEARCH;
      hits_n = '0;
    end else begin
      case (st)
        MS_SEARCH: begin
          if (first_ok) begin
            st_n   = start_st;
            hits_n = NW'(1);
          end
        end
        MS_COUNT: begin
          if (next_ok) begin
            hits_n = hits_inc;
            st_n   = (hits_inc == target) ? MS_POST : MS_COUNT;
          end else if (first_ok) begin
            st_n   = start_st;
            hits_n = NW'(1);
          end else if (rx_valid || (idle_cnt > gap_lim)) begin
            st_n   = MS_SEARCH;
            hits_n = '0;
          end
        end
        MS_POST: begin
          if (first_ok) begin
            st_n   = start_st;
            hits_n = NW'(1);
          end else if (rx_valid) begin
            st_n   = MS_SEARCH;
            hits_n = '0;
          end else if (idle_cnt >= post_lim) begin
            detect = 1'b1;
            st_n   = MS_SEARCH;
            hits_n = '0;
          end
        end
        default: begin
          st_n   = MS_SEARCH;
          hits_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= MS_SEARCH;
      hits <= '0;
    end else begin
      st   <= st_n;
      hits <= hits_n;
    end
  end

  assign in_search = (st == MS_SEARCH);
endmodule

// File: rtl/escdet_status.sv
module escdet_status (
  input  logic clk,
  input  logic rst_n,
  input  logic detect,
  input  logic clr_req,
  input  logic irq_en,
  output logic det_status,
  output logic irq
);
  // A new detection outranks a clear landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)       det_status <= 1'b0;
    else if (detect)  det_status <= 1'b1;
    else if (clr_req) det_status <= 1'b0;
  end

  assign irq = det_status & irq_en;
endmodule

// File: rtl/esc_seq_detector.sv
module esc_seq_detector
  import escdet_pkg::*;
#(
  parameter int CW = 8,
  parameter int NW = 8,
  parameter int TW = 24,
  parameter int unsigned RST_CHAR  = 8'h2B,
  parameter int unsigned RST_COUNT = 3,
  parameter int unsigned RST_GAP   = 10000,
  parameter int unsigned RST_PRE   = 10,
  parameter int unsigned RST_POST  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_byte,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  output logic          det_status,
  output logic          irq
);
  localparam logic [CW-1:0] R_CHAR  = CW'(RST_CHAR);
  localparam logic [NW-1:0] R_COUNT = NW'(RST_COUNT);
  localparam logic [TW-1:0] R_GAP   = TW'(RST_GAP);
  localparam logic [TW-1:0] R_PRE   = TW'(RST_PRE);
  localparam logic [TW-1:0] R_POST  = TW'(RST_POST);

  logic [CW-1:0] pat_char;
  logic [NW-1:0] pat_count;
  logic [TW-1:0] gap_lim, pre_lim, post_lim;
  logic          irq_en;
  logic          pat_wr_ev;
  logic          clear_ev;
  logic [TW-1:0] idle_cnt;
  logic          detect_ev;
  logic          st_search;

  escdet_cfg #(
    .CW(CW), .NW(NW), .TW(TW),
    .RST_CHAR(R_CHAR), .RST_COUNT(R_COUNT), .RST_GAP(R_GAP),
    .RST_PRE(R_PRE), .RST_POST(R_POST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pat_char(pat_char), .pat_count(pat_count), .gap_lim(gap_lim),
    .pre_lim(pre_lim), .post_lim(post_lim), .irq_en(irq_en),
    .pat_wr(pat_wr_ev), .clr_req(clear_ev)
  );

  escdet_idle #(.TW(TW)) u_idle (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .idle_cnt(idle_cnt)
  );

  escdet_match #(.CW(CW), .NW(NW), .TW(TW)) u_match (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .pat_char(pat_char), .pat_count(pat_count), .gap_lim(gap_lim),
    .pre_lim(pre_lim), .post_lim(post_lim), .idle_cnt(idle_cnt),
    .restart(pat_wr_ev), .detect(detect_ev), .in_search(st_search)
  );

  escdet_status u_status (
    .clk(clk), .rst_n(rst_n), .detect(detect_ev), .clr_req(clear_ev),
    .irq_en(irq_en), .det_status(det_status), .irq(irq)
  );
endmodule

// File: rtl/esc_seq_detector_chk.sv
module esc_seq_detector_chk #(
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          det_status,
  input logic          irq,
  input logic          detect,
  input logic          clear_req,
  input logic          pat_wr,
  input logic          in_search,
  input logic [TW-1:0] idle_cnt
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> det_status);

  p_detect_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> det_status);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_status && !clear_req) |=> det_status);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !detect) |=> !det_status);

  p_cfg_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wr |=> in_search);

  p_idle_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (idle_cnt == '0));

  p_idle_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((idle_cnt == CNT_MAX) && !rx_valid) |=> (idle_cnt == CNT_MAX));

  p_detect_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> !rx_valid);
endmodule

bind esc_seq_detector esc_seq_detector_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .det_status(det_status),
  .irq(irq), .detect(detect_ev), .clear_req(clear_ev), .pat_wr(pat_wr_ev),
  .in_search(st_search), .idle_cnt(idle_cnt)
);

// File: tb/esc_seq_detector_tb.sv
`timescale 1ns/1ps
module esc_seq_detector_tb;
  localparam int TW = 8;
  localparam int GAP_DEF = 100;
  localparam logic [7:0] PLUS = 8'h2B;
  localparam logic [7:0] OTHER = 8'h61;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic          det_status;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  esc_seq_detector #(.TW(TW), .RST_GAP(GAP_DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .det_status(det_status), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    cfg_we    = 1'b1;
    cfg_addr  = 3'(a);
    cfg_wdata = TW'(d);
    tick();
    cfg_we    = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic setup(input int cnt, input int pre, input int post, input int gap);
    wr(5, 3);
    wr(1, cnt);
    wr(3, pre);
    wr(4, post);
    wr(2, gap);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    chk("R1 status after reset", int'(det_status), 0);
    chk("R1 irq after reset", int'(irq), 0);

    // R1/R4 defaults: '+', three in a row, 10-cycle guards
    send(OTHER); idle(10);
    send(PLUS); idle(1); send(PLUS); idle(1); send(PLUS);
    idle(10);
    chk("R4 default post-guard not yet", int'(det_status), 0);
    idle(1);
    chk("R1 R4 default detection", int'(det_status), 1);
    chk("R9 irq gated off by default enable", int'(irq), 0);
    wr(5, 1);
    chk("R9 irq after enable", int'(irq), 1);
    chk("R8 enable write keeps status", int'(det_status), 1);
    wr(5, 0);
    chk("R9 irq after disable", int'(irq), 0);
    wr(5, 3);
    chk("R8 clear", int'(det_status), 0);

    // R2: pre-guard one cycle short
    setup(3, 10, 2, 5);
    send(OTHER); idle(9);
    send(PLUS); send(PLUS); send(PLUS);
    idle(12);
    chk("R2 pre-guard short", int'(det_status), 0);

    // R2: other character register value
    setup(1, 0, 0, 5);
    wr(0, 8'h23);
    send(PLUS); idle(1);
    chk("R2 wrong character ignored", int'(det_status), 0);
    send(8'h23); idle(1);
    chk("R2 programmed character", int'(det_status), 1);
    wr(0, PLUS);

    // R3: foreign character breaks a run
    setup(3, 10, 2, 5);
    send(OTHER); idle(10);
    send(PLUS); send(PLUS); send(OTHER); send(PLUS);
    idle(12);
    chk("R3 foreign byte breaks run", int'(det_status), 0);

    // R3: gap one cycle over the limit
    setup(2, 10, 2, 5);
    send(OTHER); idle(10);
    send(PLUS); idle(6); send(PLUS);
    idle(4);
    chk("R3 gap exceeded", int'(det_status), 0);

    // R5: byte during post-guard, then judged as a new first byte
    setup(3, 2, 5, 5);
    send(OTHER); idle(2);
    send(PLUS); send(PLUS); send(PLUS);
    idle(3); send(PLUS); send(PLUS); send(PLUS);
    idle(5);
    chk("R5 restarted run not yet", int'(det_status), 0);
    idle(1);
    chk("R5 cancelling byte began new run", int'(det_status), 1);
    setup(3, 2, 5, 5);
    send(OTHER); idle(2);
    send(PLUS); send(PLUS); send(PLUS);
    idle(1); send(PLUS); send(PLUS); send(PLUS);
    idle(8);
    chk("R5 cancel without pre-guard", int'(det_status), 0);

    // R6: exact pre-guard at the counter maximum, then saturation
    setup(1, 255, 0, 5);
    send(OTHER); idle(254); send(PLUS); idle(1);
    chk("R6 one short of maximum", int'(det_status), 0);
    send(OTHER); idle(255); send(PLUS);
    chk("R6 post-guard zero not yet", int'(det_status), 0);
    idle(1);
    chk("R6 at maximum", int'(det_status), 1);
    wr(5, 3);
    send(OTHER); idle(600); send(PLUS); idle(1);
    chk("R6 saturated count", int'(det_status), 1);

    // R7: pattern-register write mid-run discards the partial run
    setup(3, 1, 2, 5);
    send(OTHER); idle(1);
    send(PLUS); send(PLUS);
    wr(0, PLUS);
    send(PLUS); idle(3);
    chk("R7 write discards partial run", int'(det_status), 0);
    send(PLUS); send(PLUS); idle(3);
    chk("R7 post-write byte started fresh run", int'(det_status), 1);

    // R4: run length zero acts as one
    setup(0, 0, 0, 5);
    send(OTHER); idle(1); send(PLUS); idle(1);
    chk("R4 run length zero", int'(det_status), 1);

    // R8: detection and clear in the same cycle
    setup(1, 0, 2, 5);
    chk("R8 cleared before collision", int'(det_status), 0);
    send(PLUS); idle(2); wr(5, 3);
    chk("R8 set wins over clear", int'(det_status), 1);
    wr(5, 1);
    chk("R8 control write without clear bit", int'(det_status), 1);
    wr(5, 3);
    chk("R8 later clear", int'(det_status), 0);

    // R3/R4/R9 sweep: run length, post-guard and spacing
    for (int cnt = 1; cnt <= 4; cnt++) begin
      for (int post = 0; post <= 3; post++) begin
        for (int g = 0; g <= 3; g++) begin
          int exp_hit;
          exp_hit = (cnt == 1 || g <= 2) ? 1 : 0;
          setup(cnt, 5, post, 2);
          send(OTHER); idle(5);
          for (int i = 0; i < cnt; i++) begin
            if (i > 0) idle(g);
            send(PLUS);
          end
          idle(post);
          chk("R4 sweep before post-guard ends", int'(det_status), 0);
          idle(1);
          chk("R3 R4 sweep detection", int'(det_status), exp_hit);
          chk("R9 sweep irq", int'(irq), exp_hit);
        end
      end
    end

    summary();
  end
endmodule